// File: doc/BRIEF.md
# Multi-Port Statistics Counter Scheduler

This block sits between eight user ports and a counter memory that is split into four partitions. Each memory word can be read, written, or incremented in place by the memory itself. Every user port owns one half of one partition. Ports 0 to 3 use the lower halves of partitions 0 to 3, and ports 4 to 7 use the upper halves of the same partitions. A port can ask for a counter to be incremented or read, using a counter index. Each request waits in a small per-port queue. The block then serves the queues on a fixed time-wheel, one memory command per clock.

Every group of 15 command slots has the same shape. The first 14 slots are increment slots and the last slot is a read slot. The increment slots step through the ports in wheel order: the four lower-half ports first, then the four upper-half ports, with the wheel position carried from one group into the next. When a slot's port has nothing queued, the slot goes out as an idle command. A read command carries the number of the requesting port as a tag. The memory's response comes back with that tag, and the block sends the data only to that port.

After reset is released, the block writes zero into every word of every partition. It accepts no user request until it raises `init_done`.

Top module: `stat_sched_top`

## Requirements
- R1: After reset is released, the block issues one WRITE (opcode 3) per clock. It visits partition 0 addresses 0 up to the last address, then partitions 1, 2 and 3 in the same way. It then raises `init_done`. While `init_done` is low, `mem_op` is never RMW or READ and every ready output is low.
- R2: Port p is served in partition p mod 4. The top bit of `mem_addr` is p div 4, and the lower IDX_W bits of `mem_addr` are the request's counter index.
- R3: Increment slots serve ports in the order 0,1,...,7,0,... and the order carries across group boundaries. Read slots do not advance this order.
- R4: In each group of 15 slots counted from the first slot after `init_done`, slots 0 to 13 carry only RMW (opcode 1) or NOP (opcode 0). Slot 14 carries only READ (opcode 2) or NOP.
- R5: An increment slot whose port queue is empty goes out as NOP. No other port's request takes that slot.
- R6: Each accepted increment request produces exactly one RMW command for its counter, so a later read returns the number of accepted increments.
- R7: Each read slot serves at most one read request. It picks the first port with a pending read, scanning from one past the last port served (port 0 after reset). `mem_tag` carries that port number.
- R8: One clock after `mem_rsp_valid`, exactly one bit of `rd_rsp_valid` is set: the bit for `mem_rsp_tag`. That port's slice of `rd_rsp_data` carries the response data.
- R9: Each port queue holds QDEPTH requests. A ready output is low exactly when its queue is full, and no accepted request is lost.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| init_done | output | 1 | High once every counter word has been cleared |
| inc_valid | input | 8 | Increment request valid, one bit per port |
| inc_index | input | 8*IDX_W | Increment counter index, port p at bits p*IDX_W upward |
| inc_ready | output | 8 | Increment queue can accept, one bit per port |
| rd_valid | input | 8 | Read request valid, one bit per port |
| rd_index | input | 8*IDX_W | Read counter index, port p at bits p*IDX_W upward |
| rd_ready | output | 8 | Read queue can accept, one bit per port |
| rd_rsp_valid | output | 8 | Read data valid, one bit per port |
| rd_rsp_data | output | 8*CNT_W | Read data, port p at bits p*CNT_W upward |
| mem_op | output | 2 | Command opcode: 0 NOP, 1 RMW increment, 2 READ, 3 WRITE zero |
| mem_part | output | 2 | Target partition |
| mem_addr | output | IDX_W+1 | Half bit followed by counter index |
| mem_tag | output | 3 | Port number of the command |
| mem_rsp_valid | input | 1 | Read response valid |
| mem_rsp_tag | input | 3 | Tag of the response |
| mem_rsp_data | input | CNT_W | Counter value returned |

## Verification
The bench starts its memory model with non-zero contents. If a design skipped any word during clearing, a later read of an untouched counter would return that non-zero pattern instead of zero. The bench predicts every slot from its own wheel and round-robin pointers. A design that let a busy port steal an idle port's slot, or that advanced the wheel on read slots, would show the wrong partition or a non-idle command. A burst on one port fills its queue. This catches a design that drops ready too late, which would lose a request and undercount, or too early, which would stall the port. Reads are raised on all eight ports in the same cycle. A wrong scan start or wrong tag routing would then deliver data out of order or to the wrong port.

// File: rtl/stat_sched_pkg.sv
// Shared definitions for the statistics counter scheduler.
// Assumes: opcodes are 2 bits wide and the bench and memory use the same encoding.
package stat_sched_pkg;
    typedef enum logic [1:0] {
        OP_NOP  = 2'd0,
        OP_RMW  = 2'd1,
        OP_READ = 2'd2,
        OP_WR0  = 2'd3
    } mem_op_e;
endpackage

// File: rtl/stat_req_fifo.sv
// Per-port request queue with a ready/valid write side and a show-ahead read side.
// Assumes: pop is asserted only when the queue is not empty. en gates acceptance.
module stat_req_fifo #(
    parameter int W     = 18,
    parameter int DEPTH = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en,
    input  logic         in_valid,
    output logic         in_ready,
    input  logic [W-1:0] in_data,
    input  logic         pop,
    output logic [W-1:0] out_data,
    output logic         empty
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [W-1:0]  store [DEPTH];
    logic [PW-1:0] wr_ptr, rd_ptr;
    logic [CW-1:0] count;
    logic          full, push;

    assign full     = (count == CW'(DEPTH));
    assign empty    = (count == '0);
    assign in_ready = en && !full;
    assign push     = in_valid && in_ready;
    assign out_data = store[rd_ptr];

    // Storage write on an accepted request.
    always_ff @(posedge clk) begin
        if (push) store[wr_ptr] <= in_data;
    end

    // Pointer and occupancy bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push) wr_ptr <= (wr_ptr == PW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
            if (pop)  rd_ptr <= (rd_ptr == PW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
            count <= count + CW'(push) - CW'(pop);
        end
    end

    assert_no_overflow_R9: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CW'(DEPTH));
    assert_no_pop_empty_R5: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> !empty);
endmodule

// File: rtl/stat_slot_sched.sv
// Time-wheel scheduler: clears memory after reset, then issues one command per clock.
// Each group has 14 increment slots on a rotating port wheel and one round-robin read slot.
// Assumes: NUM_PORTS = 2*NUM_PART and NUM_PART is a power of two.
module stat_slot_sched
    import stat_sched_pkg::*;
#(
    parameter int NUM_PART    = 4,
    parameter int IDX_W       = 18,
    parameter int GROUP_SLOTS = 15
) (
    input  logic                            clk,
    input  logic                            rst_n,
    output logic                            init_done,
    input  logic [2*NUM_PART-1:0]           inc_empty,
    input  logic [2*NUM_PART*IDX_W-1:0]     inc_head,
    output logic [2*NUM_PART-1:0]           inc_pop,
    input  logic [2*NUM_PART-1:0]           rd_empty,
    input  logic [2*NUM_PART*IDX_W-1:0]     rd_head,
    output logic [2*NUM_PART-1:0]           rd_pop,
    output logic [1:0]                      mem_op,
    output logic [$clog2(NUM_PART)-1:0]     mem_part,
    output logic [IDX_W:0]                  mem_addr,
    output logic [$clog2(2*NUM_PART)-1:0]   mem_tag
);
    localparam int NUM_PORTS  = 2 * NUM_PART;
    localparam int PART_W     = $clog2(NUM_PART);
    localparam int TAG_W      = $clog2(NUM_PORTS);
    localparam int ADDR_W     = IDX_W + 1;
    localparam int INIT_TOTAL = NUM_PART << ADDR_W;
    localparam int INIT_W     = PART_W + ADDR_W;
    localparam int SLOT_W     = $clog2(GROUP_SLOTS);

    logic              init_done_q;
    logic [INIT_W-1:0] init_cnt;
    logic [SLOT_W-1:0] slot_cnt;
    logic [TAG_W-1:0]  wheel, rr_ptr, rd_port, cand;
    logic              rd_found, read_slot;
    mem_op_e           op_q;
    logic [PART_W-1:0] part_q;
    logic [ADDR_W-1:0] addr_q;
    logic [TAG_W-1:0]  tag_q;
    logic [IDX_W-1:0]  inc_sel, rd_sel;

    assign read_slot = (slot_cnt == SLOT_W'(GROUP_SLOTS - 1));
    assign inc_sel   = inc_head[wheel*IDX_W +: IDX_W];
    assign rd_sel    = rd_head[rd_port*IDX_W +: IDX_W];

    // Round-robin search for the first pending read at or after rr_ptr.
    always_comb begin
        rd_found = 1'b0;
        rd_port  = '0;
        cand     = '0;
        for (int i = NUM_PORTS - 1; i >= 0; i--) begin
            cand = rr_ptr + TAG_W'(i);
            if (!rd_empty[cand]) begin
                rd_found = 1'b1;
                rd_port  = cand;
            end
        end
    end

    // Queue pop strobes for the port owning the current slot.
    generate
        for (genvar p = 0; p < NUM_PORTS; p++) begin : g_pop
            assign inc_pop[p] = init_done_q && !read_slot && (wheel == TAG_W'(p)) && !inc_empty[p];
            assign rd_pop[p]  = init_done_q && read_slot && rd_found && (rd_port == TAG_W'(p));
        end
    endgenerate

    // Clearing sequence, then the slot wheel with registered command outputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            init_done_q <= 1'b0;
            init_cnt    <= '0;
            slot_cnt    <= '0;
            wheel       <= '0;
            rr_ptr      <= '0;
            op_q        <= OP_NOP;
            part_q      <= '0;
            addr_q      <= '0;
            tag_q       <= '0;
        end else if (!init_done_q) begin
            op_q     <= OP_WR0;
            part_q   <= init_cnt[INIT_W-1 -: PART_W];
            addr_q   <= init_cnt[ADDR_W-1:0];
            tag_q    <= '0;
            init_cnt <= init_cnt + 1'b1;
            if (init_cnt == INIT_W'(INIT_TOTAL - 1)) init_done_q <= 1'b1;
        end else if (read_slot) begin
            slot_cnt <= '0;
            part_q   <= rd_port[PART_W-1:0];
            addr_q   <= {rd_port[TAG_W-1], rd_sel};
            tag_q    <= rd_port;
            if (rd_found) begin
                op_q   <= OP_READ;
                rr_ptr <= rd_port + 1'b1;
            end else begin
                op_q   <= OP_NOP;
            end
        end else begin
            slot_cnt <= slot_cnt + 1'b1;
            wheel    <= wheel + 1'b1;
            part_q   <= wheel[PART_W-1:0];
            addr_q   <= {wheel[TAG_W-1], inc_sel};
            tag_q    <= wheel;
            op_q     <= inc_empty[wheel] ? OP_NOP : OP_RMW;
        end
    end

    assign init_done = init_done_q;
    assign mem_op    = op_q;
    assign mem_part  = part_q;
    assign mem_addr  = addr_q;
    assign mem_tag   = tag_q;

    assert_no_access_before_init_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !init_done |-> (mem_op != OP_RMW && mem_op != OP_READ));
    assert_reads_spaced_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_op == OP_READ) |=> (mem_op != OP_READ));
    assert_rmw_region_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_op == OP_RMW) |-> (mem_part == mem_tag[PART_W-1:0] && mem_addr[IDX_W] == mem_tag[TAG_W-1]));
    assert_init_done_sticky_R1: assert property (@(posedge clk) disable iff (!rst_n)
        init_done |=> init_done);
endmodule

// File: rtl/stat_rsp_router.sv
// Registers a memory read response and presents it only on the port named by its tag.
// Assumes: at most one response per clock.
module stat_rsp_router #(
    parameter int NUM_PORTS = 8,
    parameter int CNT_W     = 64
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          mem_rsp_valid,
    input  logic [$clog2(NUM_PORTS)-1:0]  mem_rsp_tag,
    input  logic [CNT_W-1:0]              mem_rsp_data,
    output logic [NUM_PORTS-1:0]          rd_rsp_valid,
    output logic [NUM_PORTS*CNT_W-1:0]    rd_rsp_data
);
    localparam int TAG_W = $clog2(NUM_PORTS);

    generate
        for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
            logic hit;
            assign hit = mem_rsp_valid && (mem_rsp_tag == TAG_W'(p));

            // Per-port valid strobe and data hold register.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    rd_rsp_valid[p]                 <= 1'b0;
                    rd_rsp_data[p*CNT_W +: CNT_W]   <= '0;
                end else begin
                    rd_rsp_valid[p] <= hit;
                    if (hit) rd_rsp_data[p*CNT_W +: CNT_W] <= mem_rsp_data;
                end
            end
        end
    endgenerate

    assert_rsp_single_port_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(rd_rsp_valid));
    assert_rsp_to_tag_R8: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rsp_valid |=> rd_rsp_valid[$past(mem_rsp_tag)]);
endmodule

// File: rtl/stat_sched_top.sv
// Top of the statistics counter scheduler: per-port increment and read queues,
// the time-wheel scheduler, and the response router.
// Assumes: the memory performs the increment itself and answers READs with the command tag.
module stat_sched_top
    import stat_sched_pkg::*;
#(
    parameter int NUM_PART    = 4,
    parameter int IDX_W       = 18,
    parameter int CNT_W       = 64,
    parameter int QDEPTH      = 4,
    parameter int GROUP_SLOTS = 15
) (
    input  logic                              clk,
    input  logic                              rst_n,
    output logic                              init_done,
    input  logic [2*NUM_PART-1:0]             inc_valid,
    input  logic [2*NUM_PART*IDX_W-1:0]       inc_index,
    output logic [2*NUM_PART-1:0]             inc_ready,
    input  logic [2*NUM_PART-1:0]             rd_valid,
    input  logic [2*NUM_PART*IDX_W-1:0]       rd_index,
    output logic [2*NUM_PART-1:0]             rd_ready,
    output logic [2*NUM_PART-1:0]             rd_rsp_valid,
    output logic [2*NUM_PART*CNT_W-1:0]       rd_rsp_data,
    output logic [1:0]                        mem_op,
    output logic [$clog2(NUM_PART)-1:0]       mem_part,
    output logic [IDX_W:0]                    mem_addr,
    output logic [$clog2(2*NUM_PART)-1:0]     mem_tag,
    input  logic                              mem_rsp_valid,
    input  logic [$clog2(2*NUM_PART)-1:0]     mem_rsp_tag,
    input  logic [CNT_W-1:0]                  mem_rsp_data
);
    localparam int NUM_PORTS = 2 * NUM_PART;

    logic [NUM_PORTS-1:0]       inc_empty, inc_pop, rd_empty, rd_pop;
    logic [NUM_PORTS*IDX_W-1:0] inc_head, rd_head;

    generate
        for (genvar p = 0; p < NUM_PORTS; p++) begin : g_q
            stat_req_fifo #(.W(IDX_W), .DEPTH(QDEPTH)) i_incq (
                .clk(clk), .rst_n(rst_n), .en(init_done),
                .in_valid(inc_valid[p]), .in_ready(inc_ready[p]),
                .in_data(inc_index[p*IDX_W +: IDX_W]),
                .pop(inc_pop[p]), .out_data(inc_head[p*IDX_W +: IDX_W]),
                .empty(inc_empty[p]));
            stat_req_fifo #(.W(IDX_W), .DEPTH(QDEPTH)) i_rdq (
                .clk(clk), .rst_n(rst_n), .en(init_done),
                .in_valid(rd_valid[p]), .in_ready(rd_ready[p]),
                .in_data(rd_index[p*IDX_W +: IDX_W]),
                .pop(rd_pop[p]), .out_data(rd_head[p*IDX_W +: IDX_W]),
                .empty(rd_empty[p]));
        end
    endgenerate

    stat_slot_sched #(.NUM_PART(NUM_PART), .IDX_W(IDX_W), .GROUP_SLOTS(GROUP_SLOTS)) i_sched (
        .clk(clk), .rst_n(rst_n), .init_done(init_done),
        .inc_empty(inc_empty), .inc_head(inc_head), .inc_pop(inc_pop),
        .rd_empty(rd_empty), .rd_head(rd_head), .rd_pop(rd_pop),
        .mem_op(mem_op), .mem_part(mem_part), .mem_addr(mem_addr), .mem_tag(mem_tag));

    stat_rsp_router #(.NUM_PORTS(NUM_PORTS), .CNT_W(CNT_W)) i_router (
        .clk(clk), .rst_n(rst_n),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_tag(mem_rsp_tag), .mem_rsp_data(mem_rsp_data),
        .rd_rsp_valid(rd_rsp_valid), .rd_rsp_data(rd_rsp_data));

    assert_ready_gated_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !init_done |-> (inc_ready == '0 && rd_ready == '0));
endmodule

// File: tb/test_stat_sched_top.sv
// Scoreboard bench: drivers queue expected commands and values, a monitor compares them.
module test_stat_sched_top;
    localparam int NP = 8, PARTS = 4, IDXW = 4, CW = 64, QD = 4, GRP = 15;
    localparam int AW = IDXW + 1, MEMN = PARTS << AW;

    logic clk = 0, rst_n = 0;
    logic init_done;
    logic [NP-1:0] inc_valid = '0, inc_ready, rd_valid = '0, rd_ready, rd_rsp_valid;
    logic [NP*IDXW-1:0] inc_index = '0, rd_index = '0;
    logic [NP*CW-1:0] rd_rsp_data;
    logic [1:0] mem_op;
    logic [1:0] mem_part;
    logic [AW-1:0] mem_addr;
    logic [2:0] mem_tag, mem_rsp_tag = '0;
    logic mem_rsp_valid = 0;
    logic [CW-1:0] mem_rsp_data = '0;

    stat_sched_top #(.NUM_PART(PARTS), .IDX_W(IDXW), .CNT_W(CW), .QDEPTH(QD), .GROUP_SLOTS(GRP)) i_stat_sched_top (
        .clk(clk), .rst_n(rst_n), .init_done(init_done),
        .inc_valid(inc_valid), .inc_index(inc_index), .inc_ready(inc_ready),
        .rd_valid(rd_valid), .rd_index(rd_index), .rd_ready(rd_ready),
        .rd_rsp_valid(rd_rsp_valid), .rd_rsp_data(rd_rsp_data),
        .mem_op(mem_op), .mem_part(mem_part), .mem_addr(mem_addr), .mem_tag(mem_tag),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_tag(mem_rsp_tag), .mem_rsp_data(mem_rsp_data));

    always #10 clk = ~clk;

    int checks = 0, fails = 0, cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    logic [CW-1:0] mem [MEMN];
    int cnt [NP][1<<IDXW];
    int idxq [NP][$];
    int icyc [NP][$];
    int rdq  [NP][$];
    int rcyc [NP][$];
    longint rexp [NP][$];

    task automatic chk(bit ok, string req, string what, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic send_inc(int p, int idx);
        bit s;
        @(negedge clk);
        inc_valid[p] = 1'b1;
        inc_index[p*IDXW +: IDXW] = IDXW'(idx);
        forever begin
            s = inc_ready[p];
            @(posedge clk);
            if (s) break;
            @(negedge clk);
        end
        #1;
        idxq[p].push_back(idx);
        icyc[p].push_back(cyc);
        cnt[p][idx]++;
        inc_valid[p] = 1'b0;
    endtask

    task automatic send_rd(int p, int idx);
        bit s;
        @(negedge clk);
        rd_valid[p] = 1'b1;
        rd_index[p*IDXW +: IDXW] = IDXW'(idx);
        forever begin
            s = rd_ready[p];
            @(posedge clk);
            if (s) break;
            @(negedge clk);
        end
        #1;
        rdq[p].push_back(idx);
        rcyc[p].push_back(cyc);
        rexp[p].push_back(longint'(cnt[p][idx]));
        rd_valid[p] = 1'b0;
    endtask

    // Monitor: command stream, memory model, responses, ready flags.
    bit started = 0, rsp_pend = 0;
    int wr_k = 0, s_idx = 0, rr = 0, rsp_port = 0;
    logic [63:0] rsp_val;
    always @(negedge clk) begin
        if (rst_n) begin
            logic [NP-1:0] ev;
            ev = rsp_pend ? (NP'(1) << rsp_port) : '0;
            if (rsp_pend || rd_rsp_valid != 0)
                chk(rd_rsp_valid == ev, "R8", "response valid vector", 64'(rd_rsp_valid), 64'(ev));
            if (rsp_pend)
                chk(rd_rsp_data[rsp_port*CW +: CW] == rsp_val, "R6", "read count", rd_rsp_data[rsp_port*CW +: CW], rsp_val);
            rsp_pend = 0;
            mem_rsp_valid = 0;
            if (!started) begin
                if (!init_done)
                    chk(inc_ready == 0 && rd_ready == 0, "R1", "ready before init", 64'({inc_ready, rd_ready}), 0);
                if (mem_op == 2'd3) begin
                    chk({mem_part, mem_addr} == (PARTS*(1<<AW))'(wr_k), "R1", "clear order", 64'({mem_part, mem_addr}), 64'(wr_k));
                    mem[{mem_part, mem_addr}] = '0;
                    wr_k++;
                end
                if (init_done) begin
                    chk(wr_k == MEMN, "R1", "clear count", 64'(wr_k), 64'(MEMN));
                    started = 1;
                end
            end else begin
                int pos;
                pos = s_idx % GRP;
                if (pos == GRP - 1) begin
                    int fp;
                    fp = -1;
                    for (int i = 0; i < NP; i++) begin
                        int q;
                        q = (rr + i) % NP;
                        if (fp < 0 && rdq[q].size() > 0 && rcyc[q][0] <= cyc - 1) fp = q;
                    end
                    if (fp < 0) chk(mem_op == 2'd0, "R4", "idle read slot", 64'(mem_op), 0);
                    else begin
                        int ix;
                        ix = rdq[fp].pop_front();
                        void'(rcyc[fp].pop_front());
                        chk(mem_op == 2'd2, "R4", "read slot op", 64'(mem_op), 2);
                        chk(mem_tag == 3'(fp), "R7", "read tag order", 64'(mem_tag), 64'(fp));
                        chk(mem_part == 2'(fp % PARTS) && mem_addr == AW'({fp / PARTS, IDXW'(ix)}), "R2", "read address",
                            64'({mem_part, mem_addr}), 64'({2'(fp % PARTS), 1'(fp / PARTS), IDXW'(ix)}));
                        rsp_pend = 1;
                        rsp_port = fp;
                        rsp_val = rexp[fp].pop_front();
                        rr = (fp + 1) % NP;
                    end
                    if (mem_op == 2'd2) begin
                        mem_rsp_valid = 1;
                        mem_rsp_tag = mem_tag;
                        mem_rsp_data = mem[{mem_part, mem_addr}];
                    end
                end else begin
                    int wp;
                    wp = ((s_idx / GRP) * (GRP - 1) + pos) % NP;
                    if (idxq[wp].size() > 0 && icyc[wp][0] <= cyc - 1) begin
                        int ix;
                        ix = idxq[wp].pop_front();
                        void'(icyc[wp].pop_front());
                        chk(mem_op == 2'd1, "R3", "increment slot op", 64'(mem_op), 1);
                        chk(mem_part == 2'(wp % PARTS) && mem_addr == AW'({wp / PARTS, IDXW'(ix)}), "R2", "increment address",
                            64'({mem_part, mem_addr}), 64'({2'(wp % PARTS), 1'(wp / PARTS), IDXW'(ix)}));
                    end else
                        chk(mem_op == 2'd0, "R5", "idle increment slot", 64'(mem_op), 0);
                    if (mem_op == 2'd1) mem[{mem_part, mem_addr}] = mem[{mem_part, mem_addr}] + 1;
                end
                s_idx++;
                for (int p = 0; p < NP; p++) begin
                    chk(inc_ready[p] == (idxq[p].size() < QD), "R9", "increment ready", 64'(inc_ready[p]), 64'(idxq[p].size() < QD));
                    chk(rd_ready[p] == (rdq[p].size() < QD), "R9", "read ready", 64'(rd_ready[p]), 64'(rdq[p].size() < QD));
                end
            end
        end
    end

    task automatic run_test();
        for (int i = 0; i < MEMN; i++) mem[i] = 64'hA5A5_5A5A_DEAD_BEEF;
        repeat (4) @(negedge clk);
        chk(mem_op == 2'd0 && init_done == 0, "R1", "reset state", 64'({init_done, mem_op}), 0);
        rst_n = 1;
        wait (init_done);
        repeat (3) @(negedge clk);
        // One increment per port, then repeated increments on one counter.
        for (int p = 0; p < NP; p++) send_inc(p, p + 3);
        for (int k = 0; k < 3; k++) send_inc(2, 7);
        repeat (150) @(negedge clk);
        // Burst to fill one queue while another port trickles in.
        fork
            for (int k = 0; k < 6; k++) send_inc(3, 1);
            begin send_inc(6, 15); send_inc(6, 15); end
        join
        repeat (150) @(negedge clk);
        // Simultaneous reads on all ports, R7 round-robin order.
        for (int p = 0; p < NP; p++) begin
            automatic int q = p;
            fork send_rd(q, q + 3); join_none
        end
        wait fork;
        send_rd(3, 1);
        send_rd(2, 7);
        send_rd(6, 15);
        send_rd(1, 0);
        send_rd(7, 15);
        repeat (200) @(negedge clk);
        for (int p = 0; p < NP; p++)
            chk(idxq[p].size() == 0 && rdq[p].size() == 0, "R6", "all requests served", 64'(idxq[p].size() + rdq[p].size()), 0);
    endtask

    initial begin
        fork
            run_test();
            begin
                repeat (20000) @(posedge clk);
                fails++;
                checks++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        disable fork;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule